// File: doc/BRIEF.md
# Serial-Start Pixel Readout Sequencer

This block is the digital control core of a linear image sensor with a parameterised number of pixels (64 by default). A single-cycle start pulse, sampled on a rising clock edge while the sequencer is idle, injects one token into a shift register that has one position per pixel. On every following rising edge the token moves one position onward. The pixel that currently holds the token is selected onto the shared output, its sample switch is put into hold, and in the cycle after the token leaves that pixel its integrator is cleared before integration starts again.

An output-enable flag stands in for the tri-stated analog output. It is high only while a token is inside the register. The edge that pushes the token out of the last position ends the final pixel's output and returns the logic to idle, so a new start is accepted no sooner than the edge after that one. A start that arrives while a token is still in the register is rejected: no second token is injected, and a sticky protocol-error flag is set. The analog integration and amplification are not modelled.

The controller is a three-state machine. IDLE (register empty) moves to SCAN on an accepted start. SCAN (token in positions 0 to NPIX-2) moves to LAST when the token enters the final position. LAST moves back to IDLE on the next edge, which is the terminating edge. Every SCAN and LAST edge that sees the start input high is a rejected restart. A synchronous reset returns the machine to IDLE and clears every register, which flushes the power-up contents.

Top module: `pixel_scan_seq`

## Requirements
- R1: In IDLE, a rising edge with `start_i` high places the token in pixel 0, so `sel_o[0]` is high in the cycle that follows that edge.
- R2: The token moves up one index (bit i to bit i+1) on each rising edge. `sel_o` is never more than one-hot, and pixel k is selected in the cycle after the (k+1)-th edge, counting the capturing edge as edge 1.
- R3: `hold_o[i]` is high exactly while pixel i is selected and low (sampling) in every other cycle.
- R4: `clr_o[i]` is high for exactly the one cycle that follows the edge on which the token leaves position i, and is low at all other times.
- R5: `oen_o` is high exactly while a token is in the register. The (NPIX+1)-th edge, counted from the capturing edge, removes the token from the last position and drives `oen_o` low.
- R6: A start sampled on the (NPIX+2)-th edge, the first edge on which the register is empty, is accepted and begins a new readout with no idle gap.
- R7: A start sampled on any edge from the 2nd to the (NPIX+1)-th, including a start held high for a second edge, injects no token and sets `perr_o`. `perr_o` then stays high until reset.
- R8: With `rst` high at a rising edge, `sel_o`, `hold_o`, `clr_o`, `oen_o` and `perr_o` are all low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Serial start pulse |
| sel_o | output | NPIX | One-hot select of the pixel driving the shared output |
| hold_o | output | NPIX | Per-pixel sample switch in hold (1) or sampling (0) |
| clr_o | output | NPIX | Per-pixel integrator clear |
| oen_o | output | 1 | Output drive enable; low represents high impedance |
| perr_o | output | 1 | Sticky flag for a restart that came too early |

## Verification
The bench applies several start patterns:
- **Isolated single-cycle pulse.** Shows the token's full path through every pixel, and the point at which the output enable falls.
- **Restart on the first permitted edge.** Separates "empty register" from "one cycle later" as the condition for accepting a start.
- **Start held high for two edges.** Separates a rejected restart from a second injected token.
- **Start on the terminating edge.** Checks that the final position still counts as in flight.
- **Random pulses.** A stretch of random start pulses is compared cycle by cycle against a queue-free integer model of the token position. This catches off-by-one faults in select, hold, clear and enable timing, as well as a sticky flag that is lost.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_LAST = 2'd2
    } seq_state_t;

endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
    import pss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic near_last_i,
    output logic inject_o,
    output logic oen_o,
    output logic perr_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       reject;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)     state_d = ST_SCAN;
            ST_SCAN: if (near_last_i) state_d = ST_LAST;
            ST_LAST:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        inject_o = 1'b0;
        oen_o    = 1'b0;
        reject   = 1'b0;
        unique case (state_q)
            ST_IDLE: inject_o = start_i;
            ST_SCAN: begin
                oen_o  = 1'b1;
                reject = start_i;
            end
            ST_LAST: begin
                oen_o  = 1'b1;
                reject = start_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            perr_o <= 1'b0;
        end else if (reject) begin
            perr_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pss_token.sv
module pss_token #(
    parameter int NPIX = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inject_i,
    output logic [NPIX-1:0] tok_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_o <= '0;
        end else begin
            tok_o <= {tok_o[NPIX-2:0], inject_i};
        end
    end

endmodule

// File: rtl/pss_pixel_ctl.sv
module pss_pixel_ctl #(
    parameter int NPIX = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIX-1:0] tok_i,
    output logic [NPIX-1:0] hold_o,
    output logic [NPIX-1:0] clr_o
);

    for (genvar g = 0; g < NPIX; g++) begin : g_pix
        logic was_sel_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                was_sel_q <= 1'b0;
            end else begin
                was_sel_q <= tok_i[g];
            end
        end

        assign hold_o[g] = tok_i[g];
        assign clr_o[g]  = was_sel_q;
    end

endmodule

// File: rtl/pixel_scan_seq.sv
module pixel_scan_seq #(
    parameter int NPIX = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    output logic [NPIX-1:0] sel_o,
    output logic [NPIX-1:0] hold_o,
    output logic [NPIX-1:0] clr_o,
    output logic            oen_o,
    output logic            perr_o
);

    localparam int LAST_IDX = NPIX - 1;

    logic            inject;
    logic [NPIX-1:0] tok;

    pss_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .near_last_i (tok[LAST_IDX-1]),
        .inject_o    (inject),
        .oen_o       (oen_o),
        .perr_o      (perr_o)
    );

    pss_token #(.NPIX(NPIX)) u_token (
        .clk      (clk),
        .rst      (rst),
        .inject_i (inject),
        .tok_o    (tok)
    );

    pss_pixel_ctl #(.NPIX(NPIX)) u_pix (
        .clk    (clk),
        .rst    (rst),
        .tok_i  (tok),
        .hold_o (hold_o),
        .clr_o  (clr_o)
    );

    assign sel_o = tok;

endmodule

// File: rtl/pss_chk.sv
module pss_chk #(
    parameter int NPIX = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic [NPIX-1:0] sel_o,
    input logic [NPIX-1:0] hold_o,
    input logic [NPIX-1:0] clr_o,
    input logic            oen_o,
    input logic            perr_o
);

    assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (!oen_o && start_i) |=> sel_o[0]);

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        ((sel_o != '0) && !sel_o[NPIX-1]) |=> (sel_o == ($past(sel_o) << 1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (hold_o == sel_o));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (clr_o == $past(sel_o)));

    assert_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (oen_o == (sel_o != '0)));

    assert_exit_R5: assert property (@(posedge clk) disable iff (rst)
        sel_o[NPIX-1] |=> !oen_o);

    assert_reject_R7: assert property (@(posedge clk) disable iff (rst)
        (oen_o && start_i) |=> (!sel_o[0] && perr_o));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        perr_o |=> perr_o);

    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (!oen_o && !perr_o && (sel_o == '0) && (clr_o == '0)));

endmodule

bind pixel_scan_seq pss_chk #(.NPIX(NPIX)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .sel_o   (sel_o),
    .hold_o  (hold_o),
    .clr_o   (clr_o),
    .oen_o   (oen_o),
    .perr_o  (perr_o)
);

// File: tb/pixel_scan_seq_tb_top.sv
`timescale 1ns/1ps
module pixel_scan_seq_tb_top;

    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] sel, hold, clr;
    logic         oen, perr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit cmp_on = 1'b0;

    int m_pos  = -1;
    int m_clrp = -1;
    bit m_err  = 1'b0;

    always #2.5 clk = ~clk;

    pixel_scan_seq #(.NPIX(N)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .sel_o   (sel),
        .hold_o  (hold),
        .clr_o   (clr),
        .oen_o   (oen),
        .perr_o  (perr)
    );

    // Behavioural reference: integer token position, updated at each edge.
    always @(posedge clk) begin
        if (rst) begin
            m_pos  = -1;
            m_clrp = -1;
            m_err  = 1'b0;
        end else begin
            bit busy;
            busy   = (m_pos >= 0);
            m_clrp = m_pos;
            if (busy) begin
                m_pos = m_pos + 1;
                if (m_pos == N) m_pos = -1;
            end
            if (start) begin
                if (busy) m_err = 1'b1;
                else      m_pos = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            logic [N-1:0] e_sel, e_clr;
            e_sel = '0;
            e_clr = '0;
            if (m_pos >= 0)  e_sel[m_pos]  = 1'b1;
            if (m_clrp >= 0) e_clr[m_clrp] = 1'b1;
            chk(sel == e_sel, "R2 select", sel, e_sel);
            chk(hold == e_sel, "R3 hold", hold, e_sel);
            chk(clr == e_clr, "R4 clear", clr, e_clr);
            chk(oen == (m_pos >= 0), "R5 enable", N'(oen), N'(m_pos >= 0));
            chk(perr == m_err, "R7 error", N'(perr), N'(m_err));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive start high for exactly the next edge.
    task automatic pulse();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        cyc(3);
        chk(sel == '0 && clr == '0 && !oen && !perr, "R8 reset state", sel, '0);
        rst = 1'b0;
        cmp_on = 1'b1;
        cyc(2);

        // Isolated pulse; restart on the first permitted edge.
        pulse();                               // edge 1 captured
        chk(sel[0] == 1'b1, "R1 capture", sel, N'(1));
        cyc(2);                                // after edge 3
        chk(sel[2] == 1'b1, "R2 position after edge 3", sel, N'(4));
        cyc(N - 2);                            // after edge N+1
        chk(!oen, "R5 enable low after terminating edge", N'(oen), '0);
        chk(clr[N-1] == 1'b1, "R4 clear of last pixel", clr, {1'b1, {(N-1){1'b0}}});
        pulse();                               // edge N+2
        chk(sel[0] && !perr, "R6 restart accepted on first empty edge", sel, N'(1));
        cyc(N + 2);
        chk(!oen && !perr, "R6 second readout completes cleanly", N'(oen), '0);

        // Start held high for two edges.
        start = 1'b1;
        cyc(2);
        start = 1'b0;
        chk($countones(sel) == 1 && sel[1] && perr, "R7 held start rejected", sel, N'(2));
        cyc(N);
        chk(!oen && perr, "R7 flag sticky after readout", N'(perr), N'(1));

        // Reset clears the flag; start on the terminating edge.
        rst = 1'b1;
        cyc(1);
        chk(!perr && !oen && clr == '0, "R8 reset clears flag", N'(perr), '0);
        rst = 1'b0;
        cyc(1);
        pulse();                               // edge 1
        cyc(N - 1);                            // after edge N: token in last position
        chk(sel[N-1] && !perr, "R2 token at last position", sel, {1'b1, {(N-1){1'b0}}});
        pulse();                               // edge N+1 with start high
        chk(!oen && sel == '0 && perr, "R7 start on terminating edge rejected", sel, '0);
        cyc(3);

        // Random pulses, checked every cycle against the model.
        rst = 1'b1;
        cyc(1);
        rst = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            start = ($urandom_range(0, 29) == 0);
            @(negedge clk);
        end
        start = 1'b0;
        cyc(N + 3);

        cmp_on = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule